// File: doc/BRIEF.md
# Link Packet Framer with Duplicate Filter

This block builds outgoing radio link packets and screens incoming ones. On the transmit side a host offers a whole packet at once: payload bytes, a length, a no-acknowledge flag and a retransmit flag. The framer then shifts out one serial bit per handshake. The order is a sync byte, the receiver address, a 9-bit control field, the payload and a CRC. Every field goes most significant bit first. The bit consumer throttles the stream with a ready signal. Configuration (address width, CRC width, dynamic length) is sampled at the moment a packet is accepted.

On the receive side the block sees one summary per packet that has already passed its CRC check: the 2-bit packet ID and the received CRC value. It tells a fresh packet from a resent copy of the last accepted one. A copy is flagged so that the caller can drop it.

A rolling 2-bit ID travels in every control field. New packets advance the ID; a resend keeps it. The sync byte's polarity follows the first address bit, so the bit pattern alternates into the address.

Top module: `link_framer_top`

## Requirements
- R1: Out of reset: pkt_ready is 1, bit_valid is 0, rx_new and rx_dup are 0, and tx_pid is 0.
- R2: A packet offered while pkt_ready is 1 is taken on that clock edge. bit_valid is 1 from the next cycle, and pkt_ready stays 0 until the final bit is consumed. The stream holds 8 preamble bits, 8×A address bits, 9 control bits, 8×L payload bits and 8×C CRC bits. Payload byte 0 (pkt_data[7:0]) comes first. bit_last is 1 only on the final CRC bit, and pkt_ready is 1 again the cycle after that bit is consumed.
- R3: The preamble byte is 8'hAA when the first transmitted address bit is 1, and 8'h55 when it is 0.
- R4: The address is the low A bytes of tx_addr, sent from bit 8A-1 down to bit 0. A equals cfg_addr_len clamped to the range 3..5.
- R5: The control field, sent MSB first, is {length[5:0], id[1:0], no_ack}. The length is the payload byte count when cfg_dyn_len is 1, and 0 otherwise.
- R6: tx_pid resets to 0. A packet taken with pkt_retx=0 gets tx_pid+1, which wraps from 3 to 0. A packet taken with pkt_retx=1 reuses tx_pid. In both cases tx_pid shows the ID of the packet being sent.
- R7: cfg_crc2=0 appends CRC-8 (polynomial 0x07) and cfg_crc2=1 appends CRC-16 (polynomial 0x1021). The CRC is computed MSB first, preset to all ones, with no final inversion, over the address, control and payload bits.
- R8: While bit_valid is 1 and bit_ready is 0, bit_valid, bit_data and bit_last hold their values.
- R9: For each rx_valid cycle, exactly one of rx_new and rx_dup pulses in the next cycle. An ID different from the last accepted one gives rx_new.
- R10: The same ID with a different CRC gives rx_new, and the pair becomes the new reference.
- R11: The same ID with the same CRC gives rx_dup, and the reference is left unchanged.
- R12: The first packet after reset gives rx_new, whatever its ID and CRC.
- R13: A pkt_len above 32 is treated as 32. This applies to the payload sent and to the length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_len | input | 3 | Address bytes (clamped 3..5) |
| cfg_crc2 | input | 1 | 1 = 16-bit CRC, 0 = 8-bit CRC |
| cfg_dyn_len | input | 1 | 1 = length field carries payload size |
| tx_addr | input | 40 | Destination address, low bytes used |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Framer idle, takes a packet |
| pkt_len | input | 6 | Payload bytes (0..32) |
| pkt_no_ack | input | 1 | No-acknowledge flag for control field |
| pkt_retx | input | 1 | Resend: keep current packet ID |
| pkt_data | input | 256 | Payload, byte i at bits 8i+7:8i |
| bit_valid | output | 1 | Serial bit present |
| bit_ready | input | 1 | Consumer takes the bit |
| bit_data | output | 1 | Serial bit |
| bit_last | output | 1 | Final bit of the packet |
| tx_pid | output | 2 | ID of the current packet |
| rx_valid | input | 1 | Checked received packet summary present |
| rx_pid | input | 2 | Received packet ID |
| rx_crc | input | 16 | Received CRC value |
| rx_new | output | 1 | Packet is new |
| rx_dup | output | 1 | Packet is a duplicate |

## Verification
The assertions check the handshake on every cycle: the bit hold under stall, the exclusive idle and busy phases, and the return to idle after the last bit. They also check that the ID only steps by one and stays put on a resend, and that each received summary gets exactly one one-cycle verdict. The content of the frame can only be shown by the bench. That means preamble polarity, address width and clamping, control field layout, payload byte order and the CRC value. So can the new-versus-copy decision, which the bench compares against its own reference model over sweeps of address width, CRC width, length mode, payload lengths, stalls and colliding ID/CRC pairs.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ADDR,
    ST_CTRL,
    ST_PAY,
    ST_CRC
  } tx_state_e;

  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [15:0] CRC16_POLY = 16'h1021;

endpackage

// File: rtl/lf_crc_serial.sv
module lf_crc_serial #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  POLY = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic shift,
  input  logic din,
  output logic msb
);

  logic [W-1:0] crc_q, crc_d;
  logic         fb;
  logic         en;

  assign fb  = crc_q[W-1] ^ din;
  assign en  = clear | step | shift;
  assign msb = crc_q[W-1];

  always_comb begin
    crc_d = crc_q;
    if (clear) begin
      crc_d = '1;
    end else if (step) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (shift) begin
      crc_d = {crc_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/lf_tx_framer.sv
module lf_tx_framer
  import link_framer_pkg::*;
#(
  parameter int unsigned MAX_PAY_BYTES  = 32,
  parameter int unsigned MAX_ADDR_BYTES = 5,
  parameter int unsigned MIN_ADDR_BYTES = 3,
  parameter int unsigned LEN_W          = 6,
  parameter int unsigned PID_W          = 2,
  localparam int unsigned PAY_BITS  = MAX_PAY_BYTES * 8,
  localparam int unsigned ADDR_BITS = MAX_ADDR_BYTES * 8,
  localparam int unsigned NAB_W     = $clog2(MAX_ADDR_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NAB_W-1:0]     cfg_addr_len,
  input  logic                 cfg_crc2,
  input  logic                 cfg_dyn_len,
  input  logic [ADDR_BITS-1:0] tx_addr,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [LEN_W-1:0]     pkt_len,
  input  logic                 pkt_no_ack,
  input  logic                 pkt_retx,
  input  logic [PAY_BITS-1:0]  pkt_data,
  output logic                 bit_valid,
  input  logic                 bit_ready,
  output logic                 bit_data,
  output logic                 bit_last,
  output logic [PID_W-1:0]     tx_pid,
  output logic                 crc_clear,
  output logic                 crc_step,
  output logic                 crc_shift,
  input  logic                 crc8_msb,
  input  logic                 crc16_msb
);

  localparam int unsigned CTRL_W = LEN_W + PID_W + 1;
  localparam int unsigned CNT_W  = $clog2(PAY_BITS + 1);
  localparam int unsigned AIDX_W = $clog2(ADDR_BITS);
  localparam int unsigned PIDX_W = $clog2(PAY_BITS);
  localparam int unsigned CIDX_W = $clog2(CTRL_W);
  localparam logic [NAB_W-1:0] NAB_MIN  = NAB_W'(MIN_ADDR_BYTES);
  localparam logic [NAB_W-1:0] NAB_MAX  = NAB_W'(MAX_ADDR_BYTES);
  localparam logic [LEN_W-1:0] PLEN_MAX = LEN_W'(MAX_PAY_BYTES);

  tx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [ADDR_BITS-1:0] addr_q;
  logic [PAY_BITS-1:0]  pdata_q;
  logic [NAB_W-1:0]     nab_q, nab_d;
  logic [LEN_W-1:0]     plen_q, plen_d;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [PID_W-1:0]     pid_q, pid_d;
  logic                 pre_one_q, pre_one_d;
  logic                 crc2_q;
  logic                 take, fire, cnt_zero;
  logic [CNT_W-1:0]     cnt_dec, addr_top, pay_top, crc_top, ctrl_top;
  logic [PIDX_W-1:0]    pos;

  // capture-side values
  always_comb begin
    if (cfg_addr_len < NAB_MIN)      nab_d = NAB_MIN;
    else if (cfg_addr_len > NAB_MAX) nab_d = NAB_MAX;
    else                             nab_d = cfg_addr_len;
    plen_d    = (pkt_len > PLEN_MAX) ? PLEN_MAX : pkt_len;
    pid_d     = pkt_retx ? pid_q : pid_q + PID_W'(1);
    ctrl_d    = {(cfg_dyn_len ? plen_d : '0), pid_d, pkt_no_ack};
    pre_one_d = tx_addr[{nab_d, 3'b000} - 1'b1];
  end

  assign pkt_ready = (state_q == ST_IDLE);
  assign bit_valid = (state_q != ST_IDLE);
  assign take      = pkt_valid & pkt_ready;
  assign fire      = bit_valid & bit_ready;
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign addr_top  = CNT_W'({nab_q, 3'b000}) - CNT_W'(1);
  assign pay_top   = CNT_W'({plen_q, 3'b000}) - CNT_W'(1);
  assign crc_top   = crc2_q ? CNT_W'(15) : CNT_W'(7);
  assign ctrl_top  = CNT_W'(CTRL_W - 1);
  assign pos       = PIDX_W'(CNT_W'({plen_q, 3'b000}) - CNT_W'(1) - cnt_q);
  assign bit_last  = (state_q == ST_CRC) & cnt_zero;
  assign tx_pid    = pid_q;

  assign crc_clear = take;
  assign crc_step  = fire & ((state_q == ST_ADDR) | (state_q == ST_CTRL) |
                             (state_q == ST_PAY));
  assign crc_shift = fire & (state_q == ST_CRC);

  always_comb begin
    unique case (state_q)
      ST_PRE:  bit_data = cnt_q[0] ~^ pre_one_q;
      ST_ADDR: bit_data = addr_q[cnt_q[AIDX_W-1:0]];
      ST_CTRL: bit_data = ctrl_q[cnt_q[CIDX_W-1:0]];
      ST_PAY:  bit_data = pdata_q[{pos[PIDX_W-1:3], ~pos[2:0]}];
      ST_CRC:  bit_data = crc2_q ? crc16_msb : crc8_msb;
      default: bit_data = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          state_d = ST_PRE;
          cnt_d   = CNT_W'(7);
        end
      end
      ST_PRE: begin
        if (fire) begin
          if (cnt_zero) begin
            state_d = ST_ADDR;
            cnt_d   = addr_top;
          end else begin
            cnt_d = cnt_dec;
          end
        end
      end
      ST_ADDR: begin
        if (fire) begin
          if (cnt_zero) begin
            state_d = ST_CTRL;
            cnt_d   = ctrl_top;
          end else begin
            cnt_d = cnt_dec;
          end
        end
      end
      ST_CTRL: begin
        if (fire) begin
          if (cnt_zero) begin
            if (plen_q == '0) begin
              state_d = ST_CRC;
              cnt_d   = crc_top;
            end else begin
              state_d = ST_PAY;
              cnt_d   = pay_top;
            end
          end else begin
            cnt_d = cnt_dec;
          end
        end
      end
      ST_PAY: begin
        if (fire) begin
          if (cnt_zero) begin
            state_d = ST_CRC;
            cnt_d   = crc_top;
          end else begin
            cnt_d = cnt_dec;
          end
        end
      end
      ST_CRC: begin
        if (fire) begin
          if (cnt_zero) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_dec;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pid_q     <= '0;
      nab_q     <= NAB_MIN;
      plen_q    <= '0;
      ctrl_q    <= '0;
      pre_one_q <= 1'b0;
      crc2_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (take) begin
        pid_q     <= pid_d;
        nab_q     <= nab_d;
        plen_q    <= plen_d;
        ctrl_q    <= ctrl_d;
        pre_one_q <= pre_one_d;
        crc2_q    <= cfg_crc2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q  <= tx_addr;
      pdata_q <= pkt_data;
    end
  end

endmodule

// File: rtl/lf_dup_filter.sv
module lf_dup_filter #(
  parameter int unsigned PID_W = 2,
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [PID_W-1:0] rx_pid,
  input  logic [CRC_W-1:0] rx_crc,
  output logic             rx_new,
  output logic             rx_dup
);

  // an extra top bit set at reset keeps the stored pair from matching
  logic [PID_W:0] last_pid_q;
  logic [CRC_W:0] last_crc_q;
  logic           same_pair;
  logic           new_d, dup_d;

  assign same_pair = (last_pid_q == {1'b0, rx_pid}) &&
                     (last_crc_q == {1'b0, rx_crc});
  assign new_d = rx_valid & ~same_pair;
  assign dup_d = rx_valid &  same_pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pid_q <= {1'b1, {PID_W{1'b0}}};
      last_crc_q <= {1'b1, {CRC_W{1'b0}}};
      rx_new     <= 1'b0;
      rx_dup     <= 1'b0;
    end else begin
      rx_new <= new_d;
      rx_dup <= dup_d;
      if (new_d) begin
        last_pid_q <= {1'b0, rx_pid};
        last_crc_q <= {1'b0, rx_crc};
      end
    end
  end

endmodule

// File: rtl/link_framer_top.sv
module link_framer_top
  import link_framer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cfg_addr_len,
  input  logic         cfg_crc2,
  input  logic         cfg_dyn_len,
  input  logic [39:0]  tx_addr,
  input  logic         pkt_valid,
  output logic         pkt_ready,
  input  logic [5:0]   pkt_len,
  input  logic         pkt_no_ack,
  input  logic         pkt_retx,
  input  logic [255:0] pkt_data,
  output logic         bit_valid,
  input  logic         bit_ready,
  output logic         bit_data,
  output logic         bit_last,
  output logic [1:0]   tx_pid,
  input  logic         rx_valid,
  input  logic [1:0]   rx_pid,
  input  logic [15:0]  rx_crc,
  output logic         rx_new,
  output logic         rx_dup
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       crc_clear, crc_step, crc_shift;
  logic       crc8_msb, crc16_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  lf_tx_framer #(
    .MAX_PAY_BYTES (32),
    .MAX_ADDR_BYTES(5),
    .MIN_ADDR_BYTES(3),
    .LEN_W         (6),
    .PID_W         (2)
  ) u_framer (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cfg_addr_len(cfg_addr_len),
    .cfg_crc2    (cfg_crc2),
    .cfg_dyn_len (cfg_dyn_len),
    .tx_addr     (tx_addr),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_len     (pkt_len),
    .pkt_no_ack  (pkt_no_ack),
    .pkt_retx    (pkt_retx),
    .pkt_data    (pkt_data),
    .bit_valid   (bit_valid),
    .bit_ready   (bit_ready),
    .bit_data    (bit_data),
    .bit_last    (bit_last),
    .tx_pid      (tx_pid),
    .crc_clear   (crc_clear),
    .crc_step    (crc_step),
    .crc_shift   (crc_shift),
    .crc8_msb    (crc8_msb),
    .crc16_msb   (crc16_msb)
  );

  lf_crc_serial #(.W(8), .POLY(CRC8_POLY)) u_crc8 (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clear(crc_clear),
    .step (crc_step),
    .shift(crc_shift),
    .din  (bit_data),
    .msb  (crc8_msb)
  );

  lf_crc_serial #(.W(16), .POLY(CRC16_POLY)) u_crc16 (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clear(crc_clear),
    .step (crc_step),
    .shift(crc_shift),
    .din  (bit_data),
    .msb  (crc16_msb)
  );

  lf_dup_filter #(.PID_W(2), .CRC_W(16)) u_dup (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rx_valid(rx_valid),
    .rx_pid  (rx_pid),
    .rx_crc  (rx_crc),
    .rx_new  (rx_new),
    .rx_dup  (rx_dup)
  );

endmodule

// File: rtl/lf_checker.sv
module lf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic       pkt_retx,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic       bit_data,
  input logic       bit_last,
  input logic [1:0] tx_pid,
  input logic       rx_valid,
  input logic       rx_new,
  input logic       rx_dup
);

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_last)) // R8
    else $error("AST_BIT_HOLD");

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> !bit_valid) // R2
    else $error("AST_IDLE_EXCL");

  AST_TAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready |=> bit_valid && !pkt_ready) // R2
    else $error("AST_TAKE_START");

  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_ready && bit_last |=> pkt_ready) // R2
    else $error("AST_LAST_IDLE");

  AST_PID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_pid) |-> tx_pid == 2'($past(tx_pid) + 2'd1)) // R6
    else $error("AST_PID_STEP");

  AST_PID_RETX: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && pkt_retx |=> $stable(tx_pid)) // R6
    else $error("AST_PID_RETX");

  AST_RX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_new, rx_dup})) // R9
    else $error("AST_RX_ONE");

  AST_RX_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_new || rx_dup) // R9
    else $error("AST_RX_VERDICT");

  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rx_new && !rx_dup) // R9
    else $error("AST_RX_QUIET");

endmodule

bind link_framer_top lf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .pkt_retx (pkt_retx),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .bit_data (bit_data),
  .bit_last (bit_last),
  .tx_pid   (tx_pid),
  .rx_valid (rx_valid),
  .rx_new   (rx_new),
  .rx_dup   (rx_dup)
);

// File: tb/link_framer_top_tb.sv
`timescale 1ns/1ps
module link_framer_top_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   cfg_addr_len;
  logic         cfg_crc2, cfg_dyn_len;
  logic [39:0]  tx_addr;
  logic         pkt_valid, pkt_ready;
  logic [5:0]   pkt_len;
  logic         pkt_no_ack, pkt_retx;
  logic [255:0] pkt_data;
  logic         bit_valid, bit_ready, bit_data, bit_last;
  logic [1:0]   tx_pid;
  logic         rx_valid;
  logic [1:0]   rx_pid;
  logic [15:0]  rx_crc;
  logic         rx_new, rx_dup;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic exp_b [0:511];
  logic rec_b [0:511];
  int   model_pid = 0;
  bit   m_seen = 1'b0;
  int   m_pid = 0;
  int   m_crc = 0;

  always #10 clk = ~clk;

  link_framer_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr_len(cfg_addr_len), .cfg_crc2(cfg_crc2),
    .cfg_dyn_len(cfg_dyn_len), .tx_addr(tx_addr), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .pkt_no_ack(pkt_no_ack),
    .pkt_retx(pkt_retx), .pkt_data(pkt_data), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .bit_last(bit_last),
    .tx_pid(tx_pid), .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_crc(rx_crc),
    .rx_new(rx_new), .rx_dup(rx_dup)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int seg_bad(input int from, input int n);
    int bad = 0;
    for (int i = from; i < from + n; i++) if (rec_b[i] !== exp_b[i]) bad++;
    return bad;
  endfunction

  function automatic int crc_ref(input bit wide, input int from, input int to);
    int c = wide ? 32'hFFFF : 32'hFF;
    int top = wide ? 15 : 7;
    int poly = wide ? 32'h1021 : 32'h07;
    int mask = wide ? 32'hFFFF : 32'hFF;
    for (int i = from; i < to; i++) begin
      int fb = ((c >> top) & 1) ^ int'(exp_b[i]);
      c = (c << 1) & mask;
      if (fb != 0) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic tx_case(input int alen, input bit crc2, input bit dyn,
                         input logic [39:0] addr, input int len, input bit noack,
                         input bit retx, input bit stall, input int seed);
    int nab, plen, n, o_ctrl, o_pay, o_crc, cw, crcv, lenf, got, lastpos, cyc;
    logic [7:0] pre;
    logic [7:0] byt;
    bit rdy;
    nab  = (alen < 3) ? 3 : ((alen > 5) ? 5 : alen);
    plen = (len > 32) ? 32 : len;
    if (!retx) model_pid = (model_pid + 1) % 4;
    for (int i = 0; i < 32; i++) pkt_data[8*i +: 8] = 8'(i * 29 + seed * 7 + 1);
    pre = addr[8*nab-1] ? 8'hAA : 8'h55;
    n = 0;
    for (int i = 7; i >= 0; i--) begin exp_b[n] = pre[i]; n++; end
    for (int i = 8*nab-1; i >= 0; i--) begin exp_b[n] = addr[i]; n++; end
    o_ctrl = n;
    lenf = dyn ? plen : 0;
    for (int i = 5; i >= 0; i--) begin exp_b[n] = 1'((lenf >> i) & 1); n++; end
    for (int i = 1; i >= 0; i--) begin exp_b[n] = 1'((model_pid >> i) & 1); n++; end
    exp_b[n] = noack; n++;
    o_pay = n;
    for (int b = 0; b < plen; b++) begin
      byt = pkt_data[8*b +: 8];
      for (int i = 7; i >= 0; i--) begin exp_b[n] = byt[i]; n++; end
    end
    o_crc = n;
    cw = crc2 ? 16 : 8;
    crcv = crc_ref(crc2, 8, o_crc);
    for (int i = cw - 1; i >= 0; i--) begin exp_b[n] = 1'((crcv >> i) & 1); n++; end
    for (int i = 0; i < 512; i++) rec_b[i] = 1'bx;

    @(negedge clk);
    cfg_addr_len = 3'(alen); cfg_crc2 = crc2; cfg_dyn_len = dyn;
    tx_addr = addr; pkt_len = 6'(len); pkt_no_ack = noack; pkt_retx = retx;
    pkt_valid = 1'b1;
    chk(pkt_ready == 1'b1, "R2", "idle before offer", int'(pkt_ready), 1);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(bit_valid == 1'b1 && pkt_ready == 1'b0, "R2", "busy after take",
        int'(bit_valid), 1);
    chk(tx_pid == 2'(model_pid), "R6", "packet id", int'(tx_pid), model_pid);
    got = 0; lastpos = -1; cyc = 0;
    while (got < n && cyc < 3000) begin
      rdy = stall ? (((cyc * 5 + 3) % 7) > 1) : 1'b1;
      bit_ready = rdy;
      if (bit_valid && rdy) begin
        rec_b[got] = bit_data;
        if (bit_last) lastpos = got;
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    bit_ready = 1'b0;
    chk(got == n, "R2", "bit count", got, n);
    chk(lastpos == n - 1, "R2", "last flag position", lastpos, n - 1);
    chk(pkt_ready == 1'b1 && bit_valid == 1'b0, "R2", "idle after last",
        int'(pkt_ready), 1);
    chk(seg_bad(0, 8) == 0, "R3", "preamble mismatches", seg_bad(0, 8), 0);
    chk(seg_bad(8, 8*nab) == 0, "R4", "address mismatches", seg_bad(8, 8*nab), 0);
    chk(seg_bad(o_ctrl, 9) == 0, "R5", "control mismatches", seg_bad(o_ctrl, 9), 0);
    if (len > 32)
      chk(seg_bad(o_pay, 8*plen) == 0, "R13", "clamped payload mismatches",
          seg_bad(o_pay, 8*plen), 0);
    else
      chk(seg_bad(o_pay, 8*plen) == 0, "R2", "payload mismatches",
          seg_bad(o_pay, 8*plen), 0);
    chk(seg_bad(o_crc, cw) == 0, "R7", "crc mismatches", seg_bad(o_crc, cw), 0);
    if (stall)
      chk(seg_bad(0, n) == 0, "R8", "stalled stream mismatches", seg_bad(0, n), 0);
  endtask

  task automatic rx_case(input int pid, input int crc, input string req);
    bit expdup;
    expdup = m_seen && (pid == m_pid) && (crc == m_crc);
    if (!expdup) begin m_seen = 1'b1; m_pid = pid; m_crc = crc; end
    @(negedge clk);
    rx_valid = 1'b1; rx_pid = 2'(pid); rx_crc = 16'(crc);
    @(negedge clk);
    rx_valid = 1'b0;
    chk(rx_new == !expdup, req, "rx_new", int'(rx_new), int'(!expdup));
    chk(rx_dup == expdup, req, "rx_dup", int'(rx_dup), int'(expdup));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int k;
    int lens [4];
    int v;
    lens[0] = 0; lens[1] = 1; lens[2] = 7; lens[3] = 32;
    rst_n = 1'b0;
    cfg_addr_len = 3'd5; cfg_crc2 = 1'b0; cfg_dyn_len = 1'b0; tx_addr = '0;
    pkt_valid = 1'b0; pkt_len = '0; pkt_no_ack = 1'b0; pkt_retx = 1'b0;
    pkt_data = '0; bit_ready = 1'b0; rx_valid = 1'b0; rx_pid = '0; rx_crc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pkt_ready == 1'b1, "R1", "reset pkt_ready", int'(pkt_ready), 1);
    chk(bit_valid == 1'b0, "R1", "reset bit_valid", int'(bit_valid), 0);
    chk(rx_new == 1'b0 && rx_dup == 1'b0, "R1", "reset rx flags",
        int'({rx_new, rx_dup}), 0);
    chk(tx_pid == 2'd0, "R1", "reset tx_pid", int'(tx_pid), 0);

    // receive side: first packet, copies, changed CRC, changed ID
    rx_case(0, 32'hFFFF, "R12");
    rx_case(0, 32'hFFFF, "R11");
    rx_case(0, 32'h1234, "R10");
    rx_case(0, 32'h1234, "R11");
    rx_case(1, 32'h1234, "R9");
    rx_case(1, 32'h1234, "R11");
    rx_case(2, 32'h0000, "R9");
    v = 12345;
    for (int i = 0; i < 96; i++) begin
      v = (v * 1103515245 + 12345) & 32'h7FFFFFFF;
      rx_case((v >> 8) & 1, (v >> 12) & 1, "R9 R10 R11");
    end
    @(negedge clk);
    chk(rx_new == 1'b0 && rx_dup == 1'b0, "R9", "quiet after last summary",
        int'({rx_new, rx_dup}), 0);

    // transmit sweep over address width (with clamps), CRC width, length mode
    k = 0;
    for (int a = 2; a <= 6; a++)
      for (int c = 0; c < 2; c++)
        for (int d = 0; d < 2; d++)
          for (int li = 0; li < 4; li++) begin
            tx_case(a, 1'(c), 1'(d), 40'hA5C39E710F ^ (40'(k) * 40'h0123456789),
                    lens[li], 1'(k & 1), (k % 5) == 4, 1'((k >> 1) & 1), k);
            k++;
          end
    tx_case(5, 1'b1, 1'b1, 40'h00_0000_0001, 40, 1'b0, 1'b0, 1'b1, 3);
    tx_case(4, 1'b0, 1'b1, 40'hFF_8000_0000, 63, 1'b1, 1'b0, 1'b0, 9);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule